// File: doc/BRIEF.md
# Raster Interrupt Status Controller

This block keeps the raw interrupt status for a display raster engine and reduces it to one interrupt request line. Five event pulses come in from neighbouring logic: palette loaded, frame done, end of frame for buffer 0, end of frame for buffer 1, and the AC-bias count. Each pulse sets its own status bit for one clock. The bit is set whether or not the source is enabled. A register write port with a per-bit mask lets software set bits by writing ones and clear bits by writing zeros.

How a bit may be cleared depends on the source and the palette mode. Some bits clear on a write of zero. Others ignore writes and clear only while the raster enable is low. The palette-loaded bit changes behaviour with the palette mode: in palette-only mode it acts like the frame-done bit, and in the other modes it clears on a write. The per-source enables are registered. The interrupt line is a registered OR of the status bits that are enabled.

Top module: `raster_irq_status`

## Requirements
- R1: Status bit positions are palette loaded at bit 0, frame done at bit 1, end of frame buffer 0 at bit 2, end of frame buffer 1 at bit 3 and AC bias at bit 4. An event pulse sets its bit at the next clock edge, whatever the state of `src_en`.
- R2: In palette modes 0 (palette plus data), 2 (data only) and 3, a masked write of 0 clears the palette-loaded bit. A low raster enable does not clear it.
- R3: In palette mode 1 (palette only), a write of 0 leaves the palette-loaded bit unchanged. A low raster enable clears it at the next edge.
- R4: In every palette mode, a write of 0 leaves the frame-done bit unchanged. A low raster enable clears it at the next edge.
- R5: A masked write of 0 clears the two end-of-frame bits and the AC-bias bit. A low raster enable does not clear them.
- R6: A write sets each bit whose `wr_mask` and `wr_data` are both 1. Bits whose `wr_mask` is 0 do not change.
- R7: When a set (an event or a write of 1) and a clear (a write of 0 or a low raster enable) reach the same bit in the same cycle, the bit ends up set.
- R8: `src_en` is registered. `irq` is the registered OR, over all sources, of status AND registered enable. `irq` rises one cycle after an enabled status bit rises. It falls two cycles after the enable is removed.
- R9: A synchronous reset clears all status bits, the registered enables and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raster_en | input | 1 | Raster engine enable; a low level clears the bits that are cleared by disabling the engine |
| pal_mode | input | 2 | Palette mode: 0 palette plus data, 1 palette only, 2 data only |
| src_en | input | 5 | Per-source interrupt enables, same bit order as `status` |
| ev_pal_loaded | input | 1 | Pulse: palette load finished |
| ev_frame_done | input | 1 | Pulse: whole frame transferred |
| ev_eof0 | input | 1 | Pulse: frame from buffer 0 finished |
| ev_eof1 | input | 1 | Pulse: frame from buffer 1 finished |
| ev_bias | input | 1 | Pulse: AC-bias count reached zero |
| wr_en | input | 1 | Status write strobe |
| wr_mask | input | 5 | Bits taking part in the write |
| wr_data | input | 5 | Write data: 1 sets, 0 requests a clear |
| status | output | 5 | Raw status bits |
| irq | output | 1 | Interrupt request, active high, registered |

## Verification
The hardest case to reach from the ports is a palette-loaded bit whose clearing rule swaps with the palette mode. A write of zero and a disabled raster engine must each be tried against that bit under every mode. The bench runs a full sweep over mode, source and raster level. For each combination it sets one bit with its event and then applies a masked write of zero, with the raster enable either held high or dropped in the same cycle. This reaches every pairing of clearing rule and mode. A second sweep puts an event and a clearing write on the same bit in the same cycle to show that the set wins.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
  localparam int NSRC   = 5;
  localparam int MODE_W = 2;

  localparam int SRC_PAL  = 0;
  localparam int SRC_DONE = 1;
  localparam int SRC_EOF0 = 2;
  localparam int SRC_EOF1 = 3;
  localparam int SRC_BIAS = 4;

  typedef enum logic [MODE_W-1:0] {
    PM_PAL_DATA  = 2'd0,
    PM_PAL_ONLY  = 2'd1,
    PM_DATA_ONLY = 2'd2,
    PM_SPARE     = 2'd3
  } pal_mode_e;

  // A source whose bit is cleared by a masked write of zero
  function automatic logic wr_clearable(input int src, input logic [MODE_W-1:0] mode);
    logic r;
    case (src)
      SRC_PAL:  r = (mode != PM_PAL_ONLY);
      SRC_DONE: r = 1'b0;
      default:  r = 1'b1;
    endcase
    return r;
  endfunction

  // A source whose bit is cleared while the raster engine is off
  function automatic logic off_clearable(input int src, input logic [MODE_W-1:0] mode);
    logic r;
    case (src)
      SRC_PAL:  r = (mode == PM_PAL_ONLY);
      SRC_DONE: r = 1'b1;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic irq_any(input logic [NSRC-1:0] st, input logic [NSRC-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/rirq_clear_policy.sv
module rirq_clear_policy
  import rirq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [MODE_W-1:0] pal_mode,
  input  logic              raster_en,
  input  logic              wr_en,
  input  logic [N-1:0]      wr_mask,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      wr_clr,
  output logic [N-1:0]      off_clr
);
  for (genvar gi = 0; gi < N; gi++) begin : g_src
    assign wr_clr[gi]  = wr_en && wr_mask[gi] && !wr_data[gi] && wr_clearable(gi, pal_mode);
    assign off_clr[gi] = !raster_en && off_clearable(gi, pal_mode);
  end
endmodule

// File: rtl/rirq_status_bit.sv
module rirq_status_bit (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/rirq_irq_merge.sv
module rirq_irq_merge
  import rirq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] status,
  input  logic [N-1:0] src_en,
  output logic [N-1:0] en_q,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      en_q <= src_en;
      irq  <= irq_any(status, en_q);
    end
  end
endmodule

// File: rtl/raster_irq_status.sv
module raster_irq_status
  import rirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              raster_en,
  input  logic [MODE_W-1:0] pal_mode,
  input  logic [NSRC-1:0]   src_en,
  input  logic              ev_pal_loaded,
  input  logic              ev_frame_done,
  input  logic              ev_eof0,
  input  logic              ev_eof1,
  input  logic              ev_bias,
  input  logic              wr_en,
  input  logic [NSRC-1:0]   wr_mask,
  input  logic [NSRC-1:0]   wr_data,
  output logic [NSRC-1:0]   status,
  output logic              irq
);
  logic [NSRC-1:0] ev_vec;
  logic [NSRC-1:0] wr_set;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] wr_clr;
  logic [NSRC-1:0] off_clr;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] en_q;

  always_comb begin
    ev_vec           = '0;
    ev_vec[SRC_PAL]  = ev_pal_loaded;
    ev_vec[SRC_DONE] = ev_frame_done;
    ev_vec[SRC_EOF0] = ev_eof0;
    ev_vec[SRC_EOF1] = ev_eof1;
    ev_vec[SRC_BIAS] = ev_bias;
  end

  assign wr_set  = wr_en ? (wr_mask & wr_data) : '0;
  assign set_vec = ev_vec | wr_set;
  assign clr_vec = wr_clr | off_clr;

  rirq_clear_policy #(.N(NSRC)) u_policy (
    .pal_mode  (pal_mode),
    .raster_en (raster_en),
    .wr_en     (wr_en),
    .wr_mask   (wr_mask),
    .wr_data   (wr_data),
    .wr_clr    (wr_clr),
    .off_clr   (off_clr)
  );

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_bit
    rirq_status_bit u_bit (
      .clk (clk),
      .rst (rst),
      .set (set_vec[gi]),
      .clr (clr_vec[gi]),
      .q   (status[gi])
    );
  end

  rirq_irq_merge #(.N(NSRC)) u_merge (
    .clk    (clk),
    .rst    (rst),
    .status (status),
    .src_en (src_en),
    .en_q   (en_q),
    .irq    (irq)
  );
endmodule

// File: rtl/rirq_checker.sv
module rirq_checker
  import rirq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              raster_en,
  input logic [MODE_W-1:0] pal_mode,
  input logic              ev_pal_loaded,
  input logic              ev_frame_done,
  input logic              wr_en,
  input logic [NSRC-1:0]   wr_mask,
  input logic [NSRC-1:0]   wr_data,
  input logic [NSRC-1:0]   status,
  input logic              irq
);
  // R1
  frame_done_sets_chk: assert property (@(posedge clk) disable iff (rst)
    ev_frame_done |=> status[SRC_DONE]);

  // R3
  pal_only_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pal_mode == PM_PAL_ONLY && raster_en && status[SRC_PAL]) |=> status[SRC_PAL]);

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (raster_en && status[SRC_DONE]) |=> status[SRC_DONE]);

  // R5
  eof0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status[SRC_EOF0] && !(wr_en && wr_mask[SRC_EOF0] && !wr_data[SRC_EOF0])) |=> status[SRC_EOF0]);

  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_pal_loaded && wr_en && wr_mask[SRC_PAL] && !wr_data[SRC_PAL]) |=> status[SRC_PAL]);

  // R8
  quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |=> !irq);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status == '0 && !irq));
endmodule

bind raster_irq_status rirq_checker u_rirq_checker (
  .clk           (clk),
  .rst           (rst),
  .raster_en     (raster_en),
  .pal_mode      (pal_mode),
  .ev_pal_loaded (ev_pal_loaded),
  .ev_frame_done (ev_frame_done),
  .wr_en         (wr_en),
  .wr_mask       (wr_mask),
  .wr_data       (wr_data),
  .status        (status),
  .irq           (irq)
);

// File: tb/raster_irq_status_bench.sv
`timescale 1ns/1ps
module raster_irq_status_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raster_en = 1'b1;
  logic [1:0] pal_mode = 2'd0;
  logic [4:0] src_en = '0;
  logic [4:0] ev = '0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_mask = '0;
  logic [4:0] wr_data = '0;
  logic [4:0] status;
  logic       irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  raster_irq_status u_raster_irq_status (
    .clk(clk), .rst(rst), .raster_en(raster_en), .pal_mode(pal_mode),
    .src_en(src_en), .ev_pal_loaded(ev[0]), .ev_frame_done(ev[1]),
    .ev_eof0(ev[2]), .ev_eof1(ev[3]), .ev_bias(ev[4]),
    .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
    .status(status), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic bit exp_wclr(input int b, input int m);
    if (b == 0) return m != 1;
    return b != 1;
  endfunction

  function automatic bit exp_oclr(input int b, input int m);
    if (b == 0) return m == 1;
    return b == 1;
  endfunction

  function automatic string req_of(input int b, input int m);
    if (b == 1) return "R4";
    if (b == 0) return (m == 1) ? "R3" : "R2";
    return "R5";
  endfunction

  task automatic do_reset();
    ev = '0; wr_en = 1'b0; wr_mask = '0; wr_data = '0; raster_en = 1'b1;
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  initial begin
    step();
    do_reset();
    chk("R9 status after reset", status, 0);
    chk("R9 irq after reset", irq, 0);

    // Sweep: mode x source x raster level, event then masked write of zero
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 5; b++) begin
        for (int re = 0; re < 2; re++) begin
          do_reset();
          pal_mode = m[1:0];
          src_en = '0;
          ev[b] = 1'b1;
          step();
          ev = '0;
          chk("R1 event sets bit, enable off", status, 1 << b);
          chk("R8 irq stays low when disabled", irq, 0);
          raster_en = re[0];
          wr_en = 1'b1; wr_mask = 5'(1 << b); wr_data = '0;
          step();
          wr_en = 1'b0; raster_en = 1'b1;
          chk(req_of(b, m), status[b],
              (exp_wclr(b, m) || (re == 0 && exp_oclr(b, m))) ? 0 : 1);
          chk("R6 other bits untouched", status & ~(5'(1 << b)), 0);
        end
      end
    end

    // Set beats clear, raster off and write zero in the same cycle
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 5; b++) begin
        do_reset();
        pal_mode = m[1:0];
        raster_en = 1'b0;
        ev[b] = 1'b1;
        wr_en = 1'b1; wr_mask = 5'(1 << b); wr_data = '0;
        step();
        ev = '0; wr_en = 1'b0; raster_en = 1'b1;
        chk("R7 set wins over clear", status[b], 1);
      end
    end

    // Masked write of ones, then full write of zeros
    do_reset();
    pal_mode = 2'd0;
    wr_en = 1'b1; wr_mask = 5'b00100; wr_data = 5'b11111;
    step();
    chk("R6 masked set", status, 5'b00100);
    wr_mask = 5'b11111; wr_data = 5'b11111;
    step();
    chk("R6 set all", status, 5'b11111);
    wr_mask = 5'b11111; wr_data = 5'b00000;
    step();
    wr_en = 1'b0;
    chk("R2 R4 R5 full clear write", status, 5'b00010);

    // Interrupt timing per source
    for (int b = 0; b < 5; b++) begin
      do_reset();
      src_en = 5'(1 << b);
      step();
      ev[b] = 1'b1;
      step();
      ev = '0;
      chk("R8 status up, irq not yet", irq, 0);
      step();
      chk("R8 irq one cycle after status", irq, 1);
      src_en = '0;
      step();
      chk("R8 irq holds through enable register", irq, 1);
      step();
      chk("R8 irq drops after enable removed", irq, 0);
      src_en = ~(5'(1 << b));
      step(); step();
      chk("R8 other enables ignore this bit", irq, 0);
    end

    // Reset with everything set and enabled
    do_reset();
    src_en = 5'b11111;
    wr_en = 1'b1; wr_mask = 5'b11111; wr_data = 5'b11111;
    step();
    wr_en = 1'b0;
    step(); step();
    chk("R8 irq with all set", irq, 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R9 reset clears status", status, 0);
    chk("R9 reset clears irq", irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule